// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block drives one pulse-width-modulated output from a small register bank. A counting reference is chosen by a select bit: either every cycle of the block clock, or a single-cycle tick input from a slower time base. Only one clock domain is involved. The reference feeds a power-of-two divider, and the divided tick steps an 8-bit counter. A full period is therefore 256 divided ticks long. The output sits at its active level while the counter is below an 8-bit compare value. A polarity bit decides whether the active level is high or low.

Software starts the generator by writing a one to a start register and stops it by writing a one to a separate stop register. A status bit follows the command after a short synchronising delay, and software polls that bit to confirm the change. Compare, polarity and divider settings written while the generator runs are held back until the counter wraps, so a period is never cut short or mixed. When stopped, the counter sits at zero and the output rests at the inactive level of the current polarity.

Top module: `pwmp_top`

## Requirements
- R1: While running with divider value p and compare value c (1..255), each period is 256·2^p reference ticks long. Its active portion is c·2^p ticks at the start of the period, and the rest is inactive. The counter advances by exactly one per divided tick.
- R2: A compare value of 0 keeps the output at the inactive level for as long as the generator runs, so the duty cycle tops out at 255/256.
- R3: The divider field divides the reference by 2^p for p = 0..6. The value 7 acts exactly like 6.
- R4: Word addresses are 0 for general config, 1 for PWM config, 2 for start, 3 for stop and 4 for status. In PWM config, bits 15:8 hold the compare value, bit 4 the polarity and bits 2:0 the divider. General config bit 0 is the reference select. Status bit 0 is the running flag. Other bits read as 0, and rdata is 0 while rd_en is low. All registers reset to 0.
- R5: A reference select of 1 counts every clock cycle. A select of 0 counts only cycles where slow_tick is high.
- R6: Writing data with bit 0 set to address 2 starts the generator, and doing so to address 3 stops it. Writing data with bit 0 clear to either address has no effect.
- R7: The status bit changes two reference ticks after the command write. With the clock reference, it still shows the old value one and two cycles after the write edge, and shows the new value from the second edge after it.
- R8: With polarity 1 the active level is high. With polarity 0 the active level is low and the waveform is inverted.
- R9: Compare, polarity and divider writes made while running take effect only where the counter wraps from 255 to 0. The period in progress finishes with its old settings.
- R10: While stopped, the output holds the inactive level of the current polarity setting and the counter holds at 0. A restart begins a full period. Out of reset the output is high, because the reset polarity is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable from a slow time base |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rd_en is high |
| pwm_out | output | 1 | PWM output |

## Verification
Two events can land in the same cycle: a configuration write, and the period-wrap reload that copies configuration into the working copy. The bench writes a new compare value partway through the active portion of a period. It then measures the length of that active run, the inactive run after it, and the next active run. The current period must keep the old length, and only the following period may show the new one. Random compare, polarity and divider changes are written at arbitrary points in a period, so some of them fall on the wrap itself. Each random change is judged by the active and inactive run lengths after settling.

// File: rtl/pwmp_pkg.sv
package pwmp_pkg;
    localparam int CMP_W   = 8;
    localparam int PRE_W   = 3;
    localparam int PRE_MAX = 6;
    localparam int DIV_W   = PRE_MAX;

    localparam int CMP_LSB  = 8;
    localparam int POL_BIT  = 4;
    localparam int PRE_LSB  = 0;
    localparam int SEL_BIT  = 0;
    localparam int CMD_BIT  = 0;
    localparam int STAT_BIT = 0;

    localparam logic [2:0] A_GEN   = 3'd0;
    localparam logic [2:0] A_PWM   = 3'd1;
    localparam logic [2:0] A_START = 3'd2;
    localparam logic [2:0] A_STOP  = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pol;
        logic [PRE_W-1:0] pre;
    } pwm_cfg_t;

    function automatic pwm_cfg_t clamp_cfg(input pwm_cfg_t c);
        pwm_cfg_t r;
        r = c;
        if (c.pre > PRE_W'(PRE_MAX)) r.pre = PRE_W'(PRE_MAX);
        return r;
    endfunction
endpackage

// File: rtl/pwmp_regs.sv
module pwmp_regs
    import pwmp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              running,
    output pwm_cfg_t          cfg,
    output logic              ref_sel,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        pwm_cfg_t cfg;
        logic     sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (addr == ADDR_W'(A_GEN)) begin
                regs_d.sel = wdata[SEL_BIT];
            end else if (addr == ADDR_W'(A_PWM)) begin
                regs_d.cfg.cmp = wdata[CMP_LSB +: CMP_W];
                regs_d.cfg.pol = wdata[POL_BIT];
                regs_d.cfg.pre = wdata[PRE_LSB +: PRE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_cmd = wr_en && (addr == ADDR_W'(A_START)) && wdata[CMD_BIT];
    assign stop_cmd  = wr_en && (addr == ADDR_W'(A_STOP))  && wdata[CMD_BIT];
    assign cfg       = regs_q.cfg;
    assign ref_sel   = regs_q.sel;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(A_GEN)) begin
                rdata[SEL_BIT] = regs_q.sel;
            end else if (addr == ADDR_W'(A_PWM)) begin
                rdata[CMP_LSB +: CMP_W] = regs_q.cfg.cmp;
                rdata[POL_BIT]          = regs_q.cfg.pol;
                rdata[PRE_LSB +: PRE_W] = regs_q.cfg.pre;
            end else if (addr == ADDR_W'(A_STAT)) begin
                rdata[STAT_BIT] = running;
            end
        end
    end

    // R4
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: rtl/pwmp_timebase.sv
module pwmp_timebase #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_sel,
    input  logic slow_tick,
    input  logic start_cmd,
    input  logic stop_cmd,
    output logic ref_tick,
    output logic running
);
    typedef struct packed {
        logic                   req;
        logic [SYNC_STAGES-1:0] sync;
    } tb_state_t;

    tb_state_t st_d, st_q;

    assign ref_tick = ref_sel ? 1'b1 : slow_tick;

    always_comb begin
        st_d = st_q;
        if (start_cmd)     st_d.req = 1'b1;
        else if (stop_cmd) st_d.req = 1'b0;
        if (ref_tick)
            st_d.sync = (st_q.sync << 1) | SYNC_STAGES'(st_q.req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.sync[SYNC_STAGES-1];

    // R7
    status_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running != $past(running)) |-> $past(ref_tick));

    // R6
    status_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(st_q.sync[0]));
endmodule

// File: rtl/pwmp_core.sv
module pwmp_core
    import pwmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_tick,
    input  logic     running,
    input  pwm_cfg_t cfg,
    output logic     pwm_out
);
    typedef struct packed {
        logic [DIV_W-1:0] pdiv;
        logic [CMP_W-1:0] cnt;
        pwm_cfg_t         act;
    } core_t;

    core_t            c_d, c_q;
    logic [DIV_W-1:0] div_lim;
    logic             active;

    assign div_lim = DIV_W'((1 << c_q.act.pre) - 1);

    always_comb begin
        c_d = c_q;
        if (!running) begin
            c_d.pdiv = '0;
            c_d.cnt  = '0;
            c_d.act  = clamp_cfg(cfg);
        end else if (ref_tick) begin
            if (c_q.pdiv == div_lim) begin
                c_d.pdiv = '0;
                c_d.cnt  = c_q.cnt + CMP_W'(1);
                if (c_q.cnt == {CMP_W{1'b1}}) c_d.act = clamp_cfg(cfg);
            end else begin
                c_d.pdiv = c_q.pdiv + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active  = running && (c_q.cnt < c_q.act.cmp);
    assign pwm_out = active ? c_q.act.pol : ~c_q.act.pol;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (c_q.cnt != $past(c_q.cnt)))
            |-> (c_q.cnt == CMP_W'($past(c_q.cnt) + 1)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (c_q.cnt != '0)) |-> $stable(c_q.act));

    // R3
    pre_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.act.pre <= PRE_W'(PRE_MAX)) && (c_q.pdiv <= div_lim));

    // R2
    zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.act.cmp == '0) |-> (pwm_out == ~c_q.act.pol));

    // R10
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> (c_q.cnt == '0));
endmodule

// File: rtl/pwmp_top.sv
module pwmp_top
    import pwmp_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    pwm_cfg_t cfg;
    logic     ref_sel, start_cmd, stop_cmd, ref_tick, running;

    pwmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .running(running), .cfg(cfg),
        .ref_sel(ref_sel), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .rdata(rdata)
    );

    pwmp_timebase #(.SYNC_STAGES(SYNC_STAGES)) tbase_i (
        .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .slow_tick(slow_tick),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .ref_tick(ref_tick), .running(running)
    );

    pwmp_core core_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .running(running),
        .cfg(cfg), .pwm_out(pwm_out)
    );
endmodule

// File: tb/pwmp_top_tb_top.sv
module pwmp_top_tb_top;
    import pwmp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int settle_cyc = 300;
    int div3 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        slow_tick <= (div3 == 2);
        div3 <= (div3 == 2) ? 0 : div3 + 1;
    end

    pwmp_top dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pwm_out(pwm_out)
    );

    function automatic logic [31:0] cfg_word(input int c, input int pol, input int p);
        return (32'(c) << 8) | (32'(pol) << 4) | 32'(p);
    endfunction

    function automatic int act_len(input int c, input int p);
        int pe;
        pe = (p > 6) ? 6 : p;
        return c << pe;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wait_status(input logic val);
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(A_STAT, v);
            if (v[0] == val) return;
        end
    endtask

    task automatic settle();
        repeat (settle_cyc) @(negedge clk);
    endtask

    task automatic measure(input logic lvl, output int a_len, output int i_len);
        int g;
        g = 0; a_len = -1; i_len = -1;
        @(negedge clk);
        while (pwm_out == lvl && g < LIMIT) begin @(negedge clk); g++; end
        while (pwm_out != lvl && g < LIMIT) begin @(negedge clk); g++; end
        if (g >= LIMIT) return;
        a_len = 0;
        while (pwm_out == lvl && a_len < LIMIT) begin a_len++; @(negedge clk); end
        i_len = 0;
        while (pwm_out != lvl && i_len < LIMIT) begin i_len++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic s0, s1, s2;
        int a, b, h, l, h2, bad;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R10: reset state
        rd(A_GEN, v);  check("R4 gen reset", int'(v), 0);
        rd(A_PWM, v);  check("R4 pwm reset", int'(v), 0);
        rd(A_STAT, v); check("R4 status reset", int'(v), 0);
        check("R10 reset output", int'(pwm_out), 1);

        // R4: field layout with junk bits and divider 7
        wr(A_PWM, 32'hABCD_40FF);
        rd(A_PWM, v);  check("R4 pwm readback", int'(v), 32'h4017);
        wr(A_GEN, 32'hFFFF_FFFF);
        rd(A_GEN, v);  check("R4 gen readback", int'(v), 1);
        wr(A_PWM, cfg_word(64, 1, 0));

        // R6: start write with bit 0 clear is ignored
        wr(A_START, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        rd(A_STAT, v); check("R6 start zero ignored", int'(v[0]), 0);
        check("R6 output idle", int'(pwm_out), 0);

        // R7: start lag
        @(negedge clk);
        wr_en = 1'b1; addr = A_START; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = A_STAT;
        #1 s0 = rdata[0];
        @(negedge clk); #1 s1 = rdata[0];
        @(negedge clk); #1 s2 = rdata[0];
        rd_en = 1'b0;
        check("R7 start lag +1", int'(s0), 0);
        check("R7 start lag +2", int'(s1), 0);
        check("R7 start lag +3", int'(s2), 1);

        // R1: basic duty
        measure(1'b1, a, b);
        check("R1 active run", a, 64);
        check("R1 inactive run", b, 192);

        // R2: compare 0
        wr(A_PWM, cfg_word(0, 1, 0));
        settle();
        bad = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_out != 1'b0) bad++;
        end
        check("R2 zero compare inactive", bad, 0);

        // R8: inverted polarity
        wr(A_PWM, cfg_word(64, 0, 0));
        settle();
        measure(1'b0, a, b);
        check("R8 active low run", a, 64);
        check("R8 high run", b, 192);

        // R3: divider values
        wr(A_PWM, cfg_word(32, 1, 2));
        settle();
        measure(1'b1, a, b);
        check("R3 div4 active", a, 128);
        check("R3 div4 inactive", b, 896);
        settle_cyc = 1040;
        wr(A_PWM, cfg_word(3, 1, 7));
        settle();
        measure(1'b1, a, b);
        check("R3 div7 as 6 active", a, 192);
        check("R3 div7 as 6 inactive", b, 253 * 64);

        // R9: compare update waits for wrap
        settle_cyc = 16400;
        wr(A_PWM, cfg_word(64, 1, 0));
        settle();
        settle_cyc = 300;
        h = 0; l = 0; h2 = 0;
        @(negedge clk);
        while (pwm_out == 1'b1) @(negedge clk);
        while (pwm_out == 1'b0) @(negedge clk);
        while (pwm_out == 1'b1 && h < LIMIT) begin
            h++;
            if (h == 10) begin wr_en = 1'b1; addr = A_PWM; wdata = cfg_word(128, 1, 0); end
            else if (h == 11) wr_en = 1'b0;
            @(negedge clk);
        end
        while (pwm_out == 1'b0 && l < LIMIT) begin l++; @(negedge clk); end
        while (pwm_out == 1'b1 && h2 < LIMIT) begin h2++; @(negedge clk); end
        check("R9 current period keeps old", h, 64);
        check("R9 current inactive old", l, 192);
        check("R9 next period new", h2, 128);

        // R5: slow tick reference
        wr(A_GEN, 32'h0);
        wr(A_PWM, cfg_word(16, 1, 0));
        settle();
        measure(1'b1, a, b);
        check("R5 slow active", a, 48);
        check("R5 slow inactive", b, 720);
        settle_cyc = 800;
        wr(A_GEN, 32'h1);
        settle();
        settle_cyc = 300;
        measure(1'b1, a, b);
        check("R5 clock ref active", a, 16);

        // R6: stop with bit 0 clear is ignored
        wr(A_STOP, 32'h0);
        repeat (10) @(negedge clk);
        rd(A_STAT, v); check("R6 stop zero ignored", int'(v[0]), 1);

        // R7: stop lag
        @(negedge clk);
        wr_en = 1'b1; addr = A_STOP; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = A_STAT;
        #1 s0 = rdata[0];
        @(negedge clk); #1 s1 = rdata[0];
        @(negedge clk); #1 s2 = rdata[0];
        rd_en = 1'b0;
        check("R7 stop lag +1", int'(s0), 1);
        check("R7 stop lag +2", int'(s1), 1);
        check("R7 stop lag +3", int'(s2), 0);

        // R10: idle level follows polarity
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pwm_out != 1'b0) bad++;
        end
        check("R10 idle low pol1", bad, 0);
        wr(A_PWM, cfg_word(100, 0, 0));
        repeat (2) @(negedge clk);
        check("R10 idle high pol0", int'(pwm_out), 1);
        wr(A_PWM, cfg_word(100, 1, 1));
        wr(A_START, 32'h1);
        h = 0;
        for (int i = 0; i < 10 && pwm_out != 1'b1; i++) @(negedge clk);
        while (pwm_out == 1'b1 && h < LIMIT) begin h++; @(negedge clk); end
        check("R10 restart full period", h, 200);
        settle_cyc = 520;

        // R1 / R8 / R3: random configurations
        for (int t = 0; t < 12; t++) begin
            int c, pl, p;
            c  = $urandom_range(255, 1);
            pl = $urandom_range(1, 0);
            p  = $urandom_range(2, 0);
            repeat ($urandom_range(300, 0)) @(negedge clk);
            wr(A_PWM, cfg_word(c, pl, p));
            settle();
            measure(pl[0], a, b);
            check("R1 random active", a, act_len(c, p));
            check("R1 random inactive", b, act_len(256 - c, p));
            settle_cyc = (256 << p) + 8;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule